// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block carries out one indivisible read-modify-write on a 32-bit or 64-bit memory word. A request supplies the access size, an 8-bit operation code taken from an instruction immediate, a base value, a signed 16-bit displacement, a source operand and the current value of register zero. The unit reads the addressed word, combines it with the operands, writes the result back when the operation calls for it, and reports the old memory value to whichever register the operation names.

Atomicity is modelled with a lock output that stays high from the read phase through the write phase, so the memory side can hold off any other agent. Requests that ask for a byte or halfword access, or that carry an unknown operation code, are refused without touching memory.

Top module: `amo_unit`

## Requirements
- R1: The size input uses 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 doubleword; only word and doubleword are accepted, byte and halfword requests finish with `illegal` set.
- R2: The memory address is `dst_val` plus `offset` sign-extended to 64 bits, and it stays constant while `mem_lock` is high.
- R3: An accepted request is sampled on a rising edge with `start` high; the following cycle is a read (`mem_req` high, `mem_we` low), then one compute cycle, then one write cycle (`mem_req` and `mem_we` high), with `mem_lock` high across all three; `done` is high for exactly one cycle, four edges after the start edge.
- R4: Operation codes 8'h00/8'h01 add, 8'h40/8'h41 or, 8'h50/8'h51 and, 8'hA0/8'hA1 xor store old value combined with `src_val`; a word operation uses and writes only the low 32 bits (addition wraps at 32 bits) and `mem_wide` is high only for doubleword.
- R5: Bit 0 of the code is the fetch flag: with it set on a simple operation `src_wen` is high in the `done` cycle and `src_new` is the old memory value, zero-extended for a word; with it clear `src_wen` stays low.
- R6: Code 8'hE1 writes `src_val` to memory and returns the old value on `src_new` with `src_wen` high.
- R7: Code 8'hF1 compares the old value with `r0_val` (low 32 bits only for a word); on a match it writes `src_val`; in every case `r0_wen` is high in the `done` cycle with `r0_new` equal to the zero-extended old value, and `src_wen` stays low.
- R8: A compare-exchange that does not match performs no write and raises `done` three edges after the start edge, with the lock dropping after the compute cycle.
- R9: Any other code, 8'hE0 or 8'hF0, or a nonzero bit above bit 7 of `imm`, gives `done` and `illegal` together one edge after the start edge, with no memory request and neither write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request; sampled only when idle |
| size | input | 2 | Access size code |
| imm | input | 32 | Immediate carrying the operation code |
| dst_val | input | 64 | Base address value |
| offset | input | 16 | Signed displacement |
| src_val | input | 64 | Source operand |
| r0_val | input | 64 | Comparand for compare-exchange |
| mem_lock | output | 1 | Held across the read-modify-write |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_wide | output | 1 | 64-bit access when high, 32-bit when low |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after the read strobe |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Request refused, valid with done |
| src_wen | output | 1 | Source register update, valid with done |
| src_new | output | 64 | New source register value |
| r0_wen | output | 1 | Register zero update, valid with done |
| r0_new | output | 64 | New register zero value |

## Verification
Results fall due at fixed edge counts after the start edge: four for a completed read-modify-write, three for an unmatched compare-exchange and one for a refused request. The bench raises `start` between edges, counts rising edges until it sees `done` between edges, and compares that count with the expected latency, reading the result and write enables in that same cycle. Memory contents and the address seen on the strobes are checked after the pulse, and the cycle after it confirms that `done` has fallen.

// File: rtl/amo_pkg.sv
package amo_pkg;
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;
    localparam logic [1:0] SZ_DWRD = 2'b11;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_OR,
        OP_AND,
        OP_XOR,
        OP_XCHG,
        OP_CMPX
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CALC,
        ST_WRITE,
        ST_DONE
    } amo_state_e;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic [1:0]       size,
    input  logic [IMM_W-1:0] imm,
    output amo_op_e          op,
    output logic             fetch,
    output logic             wide,
    output logic             legal
);
    localparam int CODE_W = 8;

    logic code_ok;
    logic upper_zero;
    logic size_ok;

    always_comb begin
        code_ok = 1'b1;
        op      = OP_ADD;
        case (imm[CODE_W-1:0])
            8'h00, 8'h01: op = OP_ADD;
            8'h40, 8'h41: op = OP_OR;
            8'h50, 8'h51: op = OP_AND;
            8'hA0, 8'hA1: op = OP_XOR;
            8'hE1:        op = OP_XCHG;
            8'hF1:        op = OP_CMPX;
            default:      code_ok = 1'b0;
        endcase
        upper_zero = (imm[IMM_W-1:CODE_W] == '0);
        size_ok    = (size == SZ_WORD) || (size == SZ_DWRD);
        fetch      = imm[0];
        wide       = (size == SZ_DWRD);
        legal      = code_ok && upper_zero && size_ok;
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_op_e           op,
    input  logic              wide,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] new_val,
    output logic              do_write
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] res;
    logic              equal;

    always_comb begin
        opa = wide ? old_val : {{HALF_W{1'b0}}, old_val[HALF_W-1:0]};
        opb = wide ? src_val : {{HALF_W{1'b0}}, src_val[HALF_W-1:0]};
        case (op)
            OP_ADD:  res = opa + opb;
            OP_OR:   res = opa | opb;
            OP_AND:  res = opa & opb;
            OP_XOR:  res = opa ^ opb;
            default: res = opb;
        endcase
        new_val  = wide ? res : {{HALF_W{1'b0}}, res[HALF_W-1:0]};
        equal    = wide ? (old_val == cmp_val)
                        : (old_val[HALF_W-1:0] == cmp_val[HALF_W-1:0]);
        do_write = (op != OP_CMPX) || equal;
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16,
    parameter int IMM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        size,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] r0_val,
    output logic              mem_lock,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              illegal,
    output logic              src_wen,
    output logic [DATA_W-1:0] src_new,
    output logic              r0_wen,
    output logic [DATA_W-1:0] r0_new
);
    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = DATA_W - OFF_W;

    typedef struct packed {
        amo_state_e        state;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] r0;
        logic [DATA_W-1:0] ret;
        logic [DATA_W-1:0] wdata;
        amo_op_e           op;
        logic              fetch;
        logic              wide;
        logic              ill;
    } amo_regs_t;

    amo_regs_t r_d, r_q;

    amo_op_e           dec_op;
    logic              dec_fetch;
    logic              dec_wide;
    logic              dec_legal;
    logic [DATA_W-1:0] old_val;
    logic [DATA_W-1:0] alu_new;
    logic              alu_write;

    amo_decode #(.IMM_W(IMM_W)) u_dec (
        .size  (size),
        .imm   (imm),
        .op    (dec_op),
        .fetch (dec_fetch),
        .wide  (dec_wide),
        .legal (dec_legal)
    );

    assign old_val = r_q.wide ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (r_q.op),
        .wide     (r_q.wide),
        .old_val  (old_val),
        .src_val  (r_q.src),
        .cmp_val  (r_q.r0),
        .new_val  (alu_new),
        .do_write (alu_write)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.addr  = dst_val + {{EXT_W{offset[OFF_W-1]}}, offset};
                    r_d.src   = src_val;
                    r_d.r0    = r0_val;
                    r_d.op    = dec_op;
                    r_d.fetch = dec_fetch;
                    r_d.wide  = dec_wide;
                    r_d.ill   = !dec_legal;
                    r_d.state = dec_legal ? ST_READ : ST_DONE;
                end
            end
            ST_READ: r_d.state = ST_CALC;
            ST_CALC: begin
                r_d.ret   = old_val;
                r_d.wdata = alu_new;
                r_d.state = alu_write ? ST_WRITE : ST_DONE;
            end
            ST_WRITE: r_d.state = ST_DONE;
            default:  r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req   = (r_q.state == ST_READ) || (r_q.state == ST_WRITE);
    assign mem_we    = (r_q.state == ST_WRITE);
    assign mem_lock  = (r_q.state == ST_READ) || (r_q.state == ST_CALC) ||
                       (r_q.state == ST_WRITE);
    assign mem_wide  = r_q.wide;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign done      = (r_q.state == ST_DONE);
    assign illegal   = done && r_q.ill;
    assign src_wen   = done && !r_q.ill && r_q.fetch && (r_q.op != OP_CMPX);
    assign r0_wen    = done && !r_q.ill && (r_q.op == OP_CMPX);
    assign src_new   = r_q.ret;
    assign r0_new    = r_q.ret;

    AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock); // R3

    AST_WRITE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_lock)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && $past(mem_lock)) |-> $stable(mem_addr)); // R2

    AST_ILLEGAL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!$past(mem_req) && !src_wen && !r0_wen)); // R9

    AST_ONE_WRITE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_wen && r0_wen)); // R7
endmodule

// File: tb/sim_amo_unit.sv
module sim_amo_unit;
    typedef struct packed {
        logic [1:0]  size;
        logic [31:0] imm;
        logic [63:0] dst;
        logic [15:0] off;
        logic [63:0] src;
        logic [63:0] r0;
        logic [63:0] minit;
        logic [63:0] mexp;
        logic        ill;
        logic        swen;
        logic [63:0] snew;
        logic        rwen;
        logic [63:0] rnew;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        // R4 doubleword add, no fetch
        '{2'b11, 32'h00, 64'h100, 16'h0010, 64'h1, 64'h0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0000, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 4'd4},
        // R4 R5 word add wraps, fetch
        '{2'b10, 32'h01, 64'h140, 16'hFFF0, 64'h2, 64'h0, 64'h1234_5678_FFFF_FFFF, 64'h1234_5678_0000_0001, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFF, 1'b0, 64'h0, 4'd4},
        // R4 R5 or with fetch
        '{2'b11, 32'h41, 64'h108, 16'h0000, 64'h0F, 64'h0, 64'hF0, 64'hFF, 1'b0, 1'b1, 64'hF0, 1'b0, 64'h0, 4'd4},
        // R4 and, no fetch
        '{2'b11, 32'h50, 64'h120, 16'h0008, 64'h0FF0_0FF0_0FF0_0FF0, 64'h0, 64'hFF00_FF00_FF00_FF00, 64'h0F00_0F00_0F00_0F00, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 4'd4},
        // R4 R5 word xor with fetch
        '{2'b10, 32'hA1, 64'h100, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hAAAA_AAAA_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 1'b1, 64'h0000_0000_5555_5555, 1'b0, 64'h0, 4'd4},
        // R6 exchange
        '{2'b11, 32'hE1, 64'h138, 16'h0000, 64'h2222, 64'h0, 64'h1111, 64'h2222, 1'b0, 1'b1, 64'h1111, 1'b0, 64'h0, 4'd4},
        // R7 compare-exchange match
        '{2'b11, 32'hF1, 64'h100, 16'h0018, 64'h99, 64'h77, 64'h77, 64'h99, 1'b0, 1'b0, 64'h0, 1'b1, 64'h77, 4'd4},
        // R8 compare-exchange mismatch
        '{2'b11, 32'hF1, 64'h100, 16'h0018, 64'h99, 64'h78, 64'h77, 64'h77, 1'b0, 1'b0, 64'h0, 1'b1, 64'h77, 4'd3},
        // R7 word compare-exchange, upper bits ignored
        '{2'b10, 32'hF1, 64'h128, 16'h0000, 64'h6, 64'hFFFF_FFFF_0000_0005, 64'hDEAD_0000_0000_0005, 64'hDEAD_0000_0000_0006, 1'b0, 1'b0, 64'h0, 1'b1, 64'h5, 4'd4},
        // R1 byte size refused
        '{2'b00, 32'h00, 64'h100, 16'h0000, 64'h1, 64'h0, 64'h55, 64'h55, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 4'd1},
        // R1 halfword size refused
        '{2'b01, 32'h01, 64'h100, 16'h0000, 64'h1, 64'h0, 64'h55, 64'h55, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 4'd1},
        // R9 exchange without fetch
        '{2'b11, 32'hE0, 64'h100, 16'h0000, 64'h1, 64'h0, 64'h55, 64'h55, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 4'd1},
        // R9 compare-exchange without fetch
        '{2'b11, 32'hF0, 64'h100, 16'h0000, 64'h1, 64'h55, 64'h55, 64'h55, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 4'd1},
        // R9 unknown code
        '{2'b11, 32'h30, 64'h100, 16'h0000, 64'h1, 64'h0, 64'h55, 64'h55, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 4'd1},
        // R9 upper immediate bit set
        '{2'b10, 32'h100, 64'h100, 16'h0000, 64'h1, 64'h0, 64'h55, 64'h55, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  size = 2'b11;
    logic [31:0] imm = '0;
    logic [63:0] dst_val = '0;
    logic [15:0] offset = '0;
    logic [63:0] src_val = '0;
    logic [63:0] r0_val = '0;
    logic        mem_lock, mem_req, mem_we, mem_wide;
    logic [63:0] mem_addr, mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        done, illegal, src_wen, r0_wen;
    logic [63:0] src_new, r0_new;

    logic [63:0] mem [8];
    int          n_rd = 0;
    int          n_wr = 0;
    logic [63:0] seen_addr = '0;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    amo_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .size(size), .imm(imm),
        .dst_val(dst_val), .offset(offset), .src_val(src_val), .r0_val(r0_val),
        .mem_lock(mem_lock), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .illegal(illegal), .src_wen(src_wen), .src_new(src_new),
        .r0_wen(r0_wen), .r0_new(r0_new)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            seen_addr = mem_addr;
            if (mem_we) begin
                n_wr = n_wr + 1;
                if (mem_wide) mem[mem_addr[5:3]] = mem_wdata;
                else          mem[mem_addr[5:3]][31:0] = mem_wdata[31:0];
            end else begin
                n_rd = n_rd + 1;
                mem_rdata <= mem_wide ? mem[mem_addr[5:3]]
                                      : {32'h0, mem[mem_addr[5:3]][31:0]};
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        errors = errors + 1;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check("R3 reset done", {63'h0, done}, 64'h0);
        check("R3 reset lock", {63'h0, mem_lock}, 64'h0);
        check("R3 reset req", {63'h0, mem_req}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 idle req", {63'h0, mem_req}, 64'h0);

        for (int v = 0; v < NV; v++) begin
            logic [63:0] ea;
            int          lat;
            ea = TBL[v].dst + {{48{TBL[v].off[15]}}, TBL[v].off};
            mem[ea[5:3]] = TBL[v].minit;
            n_rd = 0;
            n_wr = 0;
            size = TBL[v].size;
            imm = TBL[v].imm;
            dst_val = TBL[v].dst;
            offset = TBL[v].off;
            src_val = TBL[v].src;
            r0_val = TBL[v].r0;
            start = 1'b1;
            lat = 0;
            for (int k = 0; k < 10; k++) begin
                @(posedge clk);
                lat = lat + 1;
                @(negedge clk);
                start = 1'b0;
                if (done) break;
            end
            check($sformatf("R3 R8 R9 latency v%0d", v), 64'(lat), 64'(TBL[v].lat));
            check($sformatf("R1 R9 illegal v%0d", v), {63'h0, illegal}, {63'h0, TBL[v].ill});
            check($sformatf("R5 src_wen v%0d", v), {63'h0, src_wen}, {63'h0, TBL[v].swen});
            if (TBL[v].swen) check($sformatf("R5 R6 src_new v%0d", v), src_new, TBL[v].snew);
            check($sformatf("R7 r0_wen v%0d", v), {63'h0, r0_wen}, {63'h0, TBL[v].rwen});
            if (TBL[v].rwen) check($sformatf("R7 R8 r0_new v%0d", v), r0_new, TBL[v].rnew);
            check($sformatf("R4 memory v%0d", v), mem[ea[5:3]], TBL[v].mexp);
            check($sformatf("R9 reads v%0d", v), 64'(n_rd), TBL[v].ill ? 64'd0 : 64'd1);
            check($sformatf("R8 writes v%0d", v), 64'(n_wr),
                  (TBL[v].ill || TBL[v].mexp == TBL[v].minit && TBL[v].imm == 32'hF1) ? 64'd0 : 64'd1);
            if (!TBL[v].ill) check($sformatf("R2 address v%0d", v), seen_addr, ea);
            @(negedge clk);
            check($sformatf("R3 done pulse v%0d", v), {63'h0, done}, 64'h0);
        end

        // R4 width flag: mem_wide low during a word read
        mem[0] = 64'h9;
        size = 2'b10; imm = 32'h00; dst_val = 64'h0; offset = 16'h0;
        src_val = 64'h1; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R4 word wide flag", {63'h0, mem_wide}, 64'h0);
        check("R3 read phase", {62'h0, mem_req, mem_we}, 64'h2);
        @(negedge clk);
        check("R3 compute lock", {63'h0, mem_lock}, 64'h1);
        @(negedge clk);
        check("R3 write phase", {62'h0, mem_req, mem_we}, 64'h3);
        @(negedge clk);
        check("R3 lock released", {63'h0, mem_lock}, 64'h0);
        check("R3 done", {63'h0, done}, 64'h1);
        check("R4 word add result", mem[0], 64'hA);
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule